// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A walk request carries the virtual address. The current level-1 table base is taken from the `root_base` input at the moment the request is accepted.

The walker reads one 32-bit entry at a time over a request/response memory port. It first reads the level-1 entry. From that entry it does one of three things:
- It stops with a page fault when the entry is not present.
- It stops at once with a 4 MB large-page mapping.
- It reads the level-2 entry and takes the 4 KB mapping or the fault from there.

Each walk ends with a one-cycle completion pulse. The physical address, the permission bits, a large-page flag and the fault level are held on the result pins until the next walk completes. Only one walk is in flight at a time.

Handshakes on the streaming edges follow these rules:
- A walk request is taken on the cycle in which `walk_valid` and `walk_ready` are both high. `walk_ready` stays low from acceptance until the cycle after the completion pulse. Anything on `walk_valid` during that time is not captured.
- A memory read is taken when `mem_req_valid` and `mem_req_ready` are both high. While `mem_req_ready` is low, the walker holds `mem_req_valid` and keeps the address stable.
- The response channel has no back-pressure. A `mem_rsp_valid` pulse is consumed only while the walker waits for a read.

Top module: `ptw_engine`

## Requirements
- R1: The walker samples `walk_vaddr` and `root_base` on acceptance. Its first memory read goes to `root_base + 4*vaddr[31:22]`.
- R2: A level-1 entry can be a table pointer: bit 0 = 1 (present) and bit 1 = 0. In that case the second read goes to `{entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R3: A level-1 entry with bit 0 = 0 ends the walk with `done_fault` and `res_fault_l2` = 0. No second read is issued, whatever the other bits hold.
- R4: A level-1 entry with bit 0 = 1 and bit 1 = 1 ends the walk with `done_ok` after one read. The result is `res_paddr = {entry[31:22], vaddr[21:0]}`, `res_perm = entry[5:2]` and `res_large` = 1.
- R5: A level-2 entry with bit 0 = 0 ends the walk with `done_fault` and `res_fault_l2` = 1.
- R6: A level-2 entry with bit 0 = 1 ends the walk with `done_ok`. The result is `res_paddr = {entry[31:12], vaddr[11:0]}`, `res_perm = entry[5:2]` and `res_large` = 0. Bit 1 of a level-2 entry, and the permission bits of a level-1 table pointer, have no effect.
- R7: Each accepted walk produces exactly one of `done_ok` and `done_fault`, high for one cycle. `walk_ready` is high again in the next cycle.
- R8: From acceptance until completion, `walk_ready` is low and `walk_valid` has no effect. The result follows the address that was accepted.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays unchanged in the next cycle.
- R10: After reset, `walk_ready` = 1, `mem_req_valid` = 0, and both completion pulses are 0.
- R11: On a fault, `res_paddr` and `res_perm` are 0 and `res_large` is 0. No partial translation is returned.

The permission field `res_perm` is laid out as {user, execute, write, read}, from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_valid | input | 1 | Walk request valid |
| walk_ready | output | 1 | Walker idle, request can be taken |
| walk_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Physical base of the level-1 table |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid (one-cycle pulse) |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_ok | output | 1 | Walk finished with a translation |
| done_fault | output | 1 | Walk finished with a page fault |
| res_paddr | output | 32 | Translated physical address |
| res_perm | output | 4 | {user, execute, write, read} |
| res_large | output | 1 | Translation came from a large page |
| res_fault_l2 | output | 1 | Fault found at level 2 (0: level 1) |

## Verification
The bench targets the corners where the three outcomes of the level-1 read split apart:
- A non-present level-1 entry that has the large-page bit set. A design that checks the large-page bit before the present bit would return a translation here instead of faulting.
- A large page whose level-1 entry has non-zero bits 21:12. A design that splices at the 4 KB boundary would corrupt the low address bits.
- A level-2 entry with bit 1 set. A design that honours bit 1 at both levels would take it for a large page.
- A level-1 table pointer with permission bits set. A design that takes permissions from the wrong level would report them.

Random memory stalls and a request held on `walk_valid` throughout each walk expose two further faults. A walker that drops or changes its read address under back-pressure is caught. So is one that re-captures the address while busy, because it then translates the wrong page.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE
  } ptw_state_e;

  // Permission field as it sits in an entry, MSB first.
  typedef struct packed {
    logic user;
    logic exec;
    logic wr;
    logic rd;
  } ptw_perm_t;

  localparam int PTE_PRESENT_BIT = 0;
  localparam int PTE_LARGE_BIT   = 1;
  localparam int PTE_PERM_LSB    = 2;
  localparam int PTE_PERM_W      = 4;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int AW    = 32,
  parameter int IW    = 10,
  parameter int SHIFT = 2
) (
  input  logic [AW-1:0] base_i,
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] offset;

  always_comb begin
    offset = AW'(idx_i) << SHIFT;
    addr_o = base_i + offset;
  end

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int OFF_W = 12
) (
  input  logic [PTE_W-1:0]       pte_i,
  output logic                   present_o,
  output logic                   large_o,
  output ptw_perm_t              perm_o,
  output logic [PTE_W-OFF_W-1:0] frame_o
);

  always_comb begin
    present_o = pte_i[PTE_PRESENT_BIT];
    large_o   = pte_i[PTE_LARGE_BIT];
    perm_o    = ptw_perm_t'(pte_i[PTE_PERM_LSB +: PTE_PERM_W]);
    frame_o   = pte_i[PTE_W-1:OFF_W];
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       walk_valid,
  input  logic       mem_req_ready,
  input  logic       mem_rsp_valid,
  input  logic       pte_present,
  input  logic       pte_large,
  output logic       walk_ready,
  output logic       accept,
  output logic       mem_req_valid,
  output logic       level2_sel,
  output logic       cap_table,
  output logic       finish,
  output logic       finish_ok,
  output logic       done_ok,
  output logic       done_fault
);

  ptw_state_e state_q, state_d;
  logic       ok_q;

  always_comb begin
    state_d   = state_q;
    finish    = 1'b0;
    finish_ok = 1'b0;
    cap_table = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (walk_valid) state_d = ST_L1_REQ;
      ST_L1_REQ:  if (mem_req_ready) state_d = ST_L1_WAIT;
      ST_L1_WAIT: begin
        if (mem_rsp_valid) begin
          if (!pte_present) begin
            finish  = 1'b1;
            state_d = ST_DONE;
          end else if (pte_large) begin
            finish    = 1'b1;
            finish_ok = 1'b1;
            state_d   = ST_DONE;
          end else begin
            cap_table = 1'b1;
            state_d   = ST_L2_REQ;
          end
        end
      end
      ST_L2_REQ:  if (mem_req_ready) state_d = ST_L2_WAIT;
      ST_L2_WAIT: begin
        if (mem_rsp_valid) begin
          finish    = 1'b1;
          finish_ok = pte_present;
          state_d   = ST_DONE;
        end
      end
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (finish) ok_q <= finish_ok;
    end
  end

  always_comb begin
    walk_ready    = (state_q == ST_IDLE);
    accept        = walk_ready & walk_valid;
    mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
    level2_sel    = (state_q == ST_L2_REQ) || (state_q == ST_L2_WAIT);
    done_ok       = (state_q == ST_DONE) &&  ok_q;
    done_fault    = (state_q == ST_DONE) && !ok_q;
  end

endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
  import ptw_pkg::*;
#(
  parameter int L1_IDX_W    = 10,
  parameter int L2_IDX_W    = 10,
  parameter int OFF_W       = 12,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              walk_valid,
  output logic                              walk_ready,
  input  logic [L1_IDX_W+L2_IDX_W+OFF_W-1:0] walk_vaddr,
  input  logic [L1_IDX_W+L2_IDX_W+OFF_W-1:0] root_base,
  output logic                              mem_req_valid,
  input  logic                              mem_req_ready,
  output logic [L1_IDX_W+L2_IDX_W+OFF_W-1:0] mem_req_addr,
  input  logic                              mem_rsp_valid,
  input  logic [L1_IDX_W+L2_IDX_W+OFF_W-1:0] mem_rsp_data,
  output logic                              done_ok,
  output logic                              done_fault,
  output logic [L1_IDX_W+L2_IDX_W+OFF_W-1:0] res_paddr,
  output logic [PTE_PERM_W-1:0]             res_perm,
  output logic                              res_large,
  output logic                              res_fault_l2
);

  localparam int AW        = L1_IDX_W + L2_IDX_W + OFF_W;
  localparam int PTE_W     = AW;
  localparam int FRAME_W   = PTE_W - OFF_W;
  localparam int BIG_OFF_W = L2_IDX_W + OFF_W;
  localparam int BIG_FRM_W = PTE_W - BIG_OFF_W;
  localparam int NLVL      = 2;

  logic            accept, level2_sel, cap_table, finish, finish_ok;
  logic            pte_present, pte_large;
  ptw_perm_t       pte_perm;
  logic [FRAME_W-1:0] pte_frame;

  logic [AW-1:0]   va_q, root_q, tbl_q;
  logic [AW-1:0]   lvl_addr [NLVL];

  logic [AW-1:0]   paddr_q;
  ptw_perm_t       perm_q;
  logic            large_q, fl2_q;

  ptw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .walk_valid    (walk_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_present   (pte_present),
    .pte_large     (pte_large),
    .walk_ready    (walk_ready),
    .accept        (accept),
    .mem_req_valid (mem_req_valid),
    .level2_sel    (level2_sel),
    .cap_table     (cap_table),
    .finish        (finish),
    .finish_ok     (finish_ok),
    .done_ok       (done_ok),
    .done_fault    (done_fault)
  );

  ptw_pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_dec (
    .pte_i     (mem_rsp_data),
    .present_o (pte_present),
    .large_o   (pte_large),
    .perm_o    (pte_perm),
    .frame_o   (pte_frame)
  );

  // One entry-address generator per table level.
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam int IW  = (g == 0) ? L1_IDX_W : L2_IDX_W;
    localparam int LSB = (g == 0) ? BIG_OFF_W : OFF_W;
    ptw_addr_gen #(.AW(AW), .IW(IW), .SHIFT(ENTRY_SHIFT)) u_ag (
      .base_i (g == 0 ? root_q : tbl_q),
      .idx_i  (va_q[LSB +: IW]),
      .addr_o (lvl_addr[g])
    );
  end

  assign mem_req_addr = level2_sel ? lvl_addr[1] : lvl_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      root_q <= '0;
      tbl_q  <= '0;
    end else begin
      if (accept) begin
        va_q   <= walk_vaddr;
        root_q <= root_base;
      end
      if (cap_table) tbl_q <= {pte_frame, {OFF_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      perm_q  <= '0;
      large_q <= 1'b0;
      fl2_q   <= 1'b0;
    end else if (finish) begin
      if (finish_ok) begin
        perm_q <= pte_perm;
        fl2_q  <= 1'b0;
        if (level2_sel) begin
          paddr_q <= {pte_frame, va_q[OFF_W-1:0]};
          large_q <= 1'b0;
        end else begin
          paddr_q <= {mem_rsp_data[PTE_W-1 -: BIG_FRM_W], va_q[BIG_OFF_W-1:0]};
          large_q <= 1'b1;
        end
      end else begin
        paddr_q <= '0;
        perm_q  <= '0;
        large_q <= 1'b0;
        fl2_q   <= level2_sel;
      end
    end
  end

  assign res_paddr    = paddr_q;
  assign res_perm     = perm_q;
  assign res_large    = large_q;
  assign res_fault_l2 = fl2_q;

endmodule

// File: rtl/ptw_engine_chk.sv
module ptw_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          walk_valid,
  input logic          walk_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          done_ok,
  input logic          done_fault,
  input logic [AW-1:0] res_paddr,
  input logic [3:0]    res_perm,
  input logic          res_large
);

  p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_fault));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_fault) |=> (!done_ok && !done_fault && walk_ready));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_busy_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !walk_ready);

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && walk_ready) |=> (!walk_ready && !done_ok && !done_fault));

  p_fault_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_fault |-> (res_paddr == '0 && res_perm == '0 && !res_large));

endmodule

bind ptw_engine ptw_engine_chk #(.AW(L1_IDX_W + L2_IDX_W + OFF_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .walk_valid    (walk_valid),
  .walk_ready    (walk_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done_ok       (done_ok),
  .done_fault    (done_fault),
  .res_paddr     (res_paddr),
  .res_perm      (res_perm),
  .res_large     (res_large)
);

// File: tb/ptw_engine_bench.sv
module ptw_engine_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_valid = 1'b0;
  logic        walk_ready;
  logic [31:0] walk_vaddr = '0;
  logic [31:0] root_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done_ok, done_fault;
  logic [31:0] res_paddr;
  logic [3:0]  res_perm;
  logic        res_large, res_fault_l2;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_engine u_ptw_engine (
    .clk(clk), .rst_n(rst_n),
    .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_vaddr(walk_vaddr),
    .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_ok(done_ok), .done_fault(done_fault),
    .res_paddr(res_paddr), .res_perm(res_perm),
    .res_large(res_large), .res_fault_l2(res_fault_l2)
  );

  int vectors = 0;
  int misses  = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [31:0] mem [int unsigned];
  int          lat = 1;
  bit          stall_mode = 0;
  bit          pend;
  int          cnt;
  logic [31:0] pend_addr;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b1;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      pend          <= 1'b0;
      cnt           <= 0;
      pend_addr     <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        pend      <= 1'b1;
        cnt       <= lat;
        pend_addr <= mem_req_addr;
      end else if (pend) begin
        if (cnt <= 1) begin
          pend          <= 1'b0;
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= rd(pend_addr);
        end else cnt <= cnt - 1;
      end
      mem_req_ready <= stall_mode ? ($urandom_range(0, 2) == 0) : 1'b1;
    end
  end

  // ---------------- reference model ----------------
  logic [31:0] exp_addr_q [$];
  string       exp_atag_q [$];
  bit          exp_ok_q [$];
  logic [31:0] exp_paddr_q [$];
  logic [3:0]  exp_perm_q [$];
  bit          exp_large_q [$];
  bit          exp_fl2_q [$];
  string       exp_tag_q [$];

  task automatic predict(input logic [31:0] va, input logic [31:0] root, input string tag);
    logic [31:0] a1, a2, e1, e2;
    a1 = root + {20'h0, va[31:22], 2'b00};
    exp_addr_q.push_back(a1); exp_atag_q.push_back("R1");
    e1 = rd(a1);
    if (!e1[0]) begin
      exp_ok_q.push_back(0); exp_paddr_q.push_back('0); exp_perm_q.push_back('0);
      exp_large_q.push_back(0); exp_fl2_q.push_back(0);
    end else if (e1[1]) begin
      exp_ok_q.push_back(1); exp_paddr_q.push_back({e1[31:22], va[21:0]});
      exp_perm_q.push_back(e1[5:2]); exp_large_q.push_back(1); exp_fl2_q.push_back(0);
    end else begin
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      exp_addr_q.push_back(a2); exp_atag_q.push_back("R2");
      e2 = rd(a2);
      if (!e2[0]) begin
        exp_ok_q.push_back(0); exp_paddr_q.push_back('0); exp_perm_q.push_back('0);
        exp_large_q.push_back(0); exp_fl2_q.push_back(1);
      end else begin
        exp_ok_q.push_back(1); exp_paddr_q.push_back({e2[31:12], va[11:0]});
        exp_perm_q.push_back(e2[5:2]); exp_large_q.push_back(0); exp_fl2_q.push_back(0);
      end
    end
    exp_tag_q.push_back(tag);
  endtask

  // ---------------- per-clock comparison ----------------
  bit          busy_m = 0;
  bit          prev_stall = 0;
  logic [31:0] prev_addr = '0;
  int          done_count = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(walk_ready == !busy_m, "R8", "walk_ready", {31'h0, walk_ready}, {31'h0, !busy_m});
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R9", "held request",
            mem_req_addr, prev_addr);
      if (mem_req_valid && mem_req_ready) begin
        if (exp_addr_q.size() == 0)
          chk(0, "R3", "unexpected read", mem_req_addr, 32'hx);
        else begin
          chk(mem_req_addr == exp_addr_q[0], exp_atag_q[0], "read address",
              mem_req_addr, exp_addr_q[0]);
          void'(exp_addr_q.pop_front()); void'(exp_atag_q.pop_front());
        end
      end
      if (done_ok || done_fault) begin
        string t;
        t = exp_tag_q.pop_front();
        chk(!(done_ok && done_fault), "R7", "both done", {done_ok, done_fault}, 32'h0);
        chk(exp_addr_q.size() == 0, t, "reads left", exp_addr_q.size(), 0);
        chk(done_ok == exp_ok_q[0], t, "done_ok", {31'h0, done_ok}, {31'h0, exp_ok_q[0]});
        chk(res_paddr == exp_paddr_q[0], t, "res_paddr", res_paddr, exp_paddr_q[0]);
        chk(res_perm == exp_perm_q[0], t, "res_perm", {28'h0, res_perm}, {28'h0, exp_perm_q[0]});
        chk(res_large == exp_large_q[0], t, "res_large", {31'h0, res_large}, {31'h0, exp_large_q[0]});
        chk(res_fault_l2 == exp_fl2_q[0], t, "res_fault_l2", {31'h0, res_fault_l2}, {31'h0, exp_fl2_q[0]});
        void'(exp_ok_q.pop_front()); void'(exp_paddr_q.pop_front()); void'(exp_perm_q.pop_front());
        void'(exp_large_q.pop_front()); void'(exp_fl2_q.pop_front());
        done_count++;
        busy_m = 0;
      end else if (walk_valid && walk_ready) busy_m = 1;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_walk(input logic [31:0] va, input string tag, input bit noise);
    int start;
    @(posedge clk); #1;
    while (!walk_ready) begin @(posedge clk); #1; end
    predict(va, root_base, tag);
    start = done_count;
    walk_valid = 1'b1;
    walk_vaddr = va;
    @(posedge clk); #1;
    if (noise) walk_vaddr = ~va;          // R8: request held during the walk
    else walk_valid = 1'b0;
    while (done_count == start) begin @(posedge clk); #1; end
    walk_valid = 1'b0;
  endtask

  localparam logic [31:0] ROOT_A = 32'h0001_0000;
  localparam logic [31:0] ROOT_B = 32'h0005_0000;

  initial begin
    mem[ROOT_A + 4]  = 32'h0002_0001;                          // table pointer
    mem[ROOT_A + 8]  = 32'h0003_0002;                          // not present, large bit set
    mem[ROOT_A + 12] = (32'h1AC << 22) | (32'h3FF << 12) | 32'h3B; // large, junk mid bits
    mem[ROOT_A + 16] = 32'h0002_403D;                          // pointer with perm bits
    mem[ROOT_A + 20] = (32'h3FF << 22) | 32'h07;               // large, read only
    for (int e = 0; e < 8; e++) begin
      mem[32'h0002_0000 + 4*e] = (e % 3 == 2) ? 32'h0 :
        (((32'h12340 + e) << 12) | ((e & 15) << 2) | 32'h1 | ((e == 4) ? 32'h2 : 32'h0));
      mem[32'h0002_4000 + 4*e] = (e == 5) ? 32'h0000_0FFC :
        (((32'h0F000 + 7*e) << 12) | 32'h15);
    end
    mem[ROOT_B + 4] = (32'h2A5 << 22) | 32'h0F;

    root_base = ROOT_A;
    repeat (3) @(posedge clk);
    #1;
    chk(walk_ready == 1'b1, "R10", "walk_ready in reset", {31'h0, walk_ready}, 32'h1);
    chk(!mem_req_valid && !done_ok && !done_fault, "R10", "idle outputs",
        {29'h0, mem_req_valid, done_ok, done_fault}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(walk_ready && !mem_req_valid && !done_ok && !done_fault, "R10", "after reset",
        {28'h0, walk_ready, mem_req_valid, done_ok, done_fault}, 32'h8);

    do_walk(32'h0040_3ABC, "R6", 0);   // small page, level-2 entry 3
    do_walk(32'h0080_0123, "R3", 0);   // level-1 absent with large bit
    do_walk(32'h00C0_0000, "R4", 0);   // large page, offset 0
    do_walk(32'h00FF_FFFF, "R4", 0);   // large page, max offset
    do_walk(32'h0040_2555, "R5", 0);   // level-2 entry 2 absent
    do_walk(32'h0040_4001, "R6", 0);   // level-2 entry with bit 1 set
    do_walk(32'h0100_3FFF, "R6", 0);   // pointer with perm bits ignored
    do_walk(32'h0100_5000, "R11", 0);  // level-2 fault after success
    do_walk(32'h0000_0000, "R3", 0);   // level-1 entry 0 absent
    do_walk(32'h0140_0777, "R4", 0);   // large read-only
    do_walk(32'h0040_1234, "R8", 1);   // held request during walk
    root_base = ROOT_B;
    do_walk(32'h0040_0042, "R1", 0);   // different root
    root_base = ROOT_A;

    stall_mode = 1;
    lat = 3;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] va;
      va = {7'h0, 3'($urandom_range(0, 7)), 7'h0, 3'($urandom_range(0, 7)), 12'($urandom)};
      do_walk(va, (i % 2) ? "R9" : "R8", i % 2 == 0);
    end

    repeat (4) @(posedge clk);
    chk(exp_tag_q.size() == 0, "R7", "walks without completion", exp_tag_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    vectors++;
    $display("FAIL R7 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule